// File: doc/BRIEF.md
# Zero-Padded Ping-Pong Segment Scheduler

This block sits in front of and behind a pair of block transform engines that perform fast convolution in the frequency domain. On the input side it takes a continuous stream of 12-bit samples and cuts it into segments of `SEG_LEN` accepted samples. The active lane carries each segment. The other lane carries zeros in the same cycles. Every lane therefore sees frames of `2*SEG_LEN` points: a segment of data followed by a zero tail of equal length. Each lane's transform start pulse is raised on the first sample of its segment. The lanes alternate on every segment, so the two starts are `SEG_LEN` accepted samples apart.

The zero tail leaves room for the full convolution tail of each segment. The two inverse-transform result streams that come back therefore overlap in time, and the block adds them into one wider output stream. There is no limit on stream length, because each frame's tail simply lands on top of the next frame's head. A fixed alignment delay line copies the start pulses `ALIGN_DLY` clock cycles later. This lets downstream control line up with the latency of the external transform and multiply path.

Top module: `seg_sched_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every valid, start, aligned-start and output-valid signal is low and all data outputs are zero.
- R2: The first sample accepted after reset goes to lane A, and `laneAStart` is high in the same output cycle.
- R3: Each accepted sample appears one clock later on the lane that owns the current segment, with its value unchanged. Ownership starts at lane A and toggles after every `SEG_LEN` accepted samples (A, B, A, ...).
- R4: Each accepted sample also raises the valid of the other lane, whose data is zero whatever the input value. This zero is the tail of that lane's frame.
- R5: A lane's start pulse is high only with the first sample of one of its segments. Start pulses for lanes A and B are therefore never high together, and they are `SEG_LEN` accepted samples apart.
- R6: A cycle with `inValid` low produces no lane valid, no start and zero lane data one clock later, and it does not advance the segment position.
- R7: One clock after its inputs, `outValid` is the OR of the two result valids. `outData` is the sign-extended signed sum of the result samples whose valid is high, and a result with valid low contributes zero.
- R8: `outData` is two bits wider than a result sample, so the sum of two full-scale positive or two full-scale negative results is exact.
- R9: `alignStartA` and `alignStartB` repeat `laneAStart` and `laneBStart` exactly `ALIGN_DLY` clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample qualifier |
| inData | input | IN_W | Input sample |
| laneAValid | output | 1 | Lane A sample valid |
| laneAData | output | IN_W | Lane A sample (data or zero tail) |
| laneAStart | output | 1 | Lane A transform start |
| laneBValid | output | 1 | Lane B sample valid |
| laneBData | output | IN_W | Lane B sample (data or zero tail) |
| laneBStart | output | 1 | Lane B transform start |
| alignStartA | output | 1 | Lane A start delayed by ALIGN_DLY cycles |
| alignStartB | output | 1 | Lane B start delayed by ALIGN_DLY cycles |
| resAValid | input | 1 | Lane A inverse-transform result valid |
| resAData | input | RES_W | Lane A result sample, signed |
| resBValid | input | 1 | Lane B inverse-transform result valid |
| resBData | input | RES_W | Lane B result sample, signed |
| outValid | output | 1 | Recombined output valid |
| outData | output | RES_W+2 | Overlap-add sum, signed |

## Verification
The lane outputs and start pulses are due one clock after the input sample that causes them. The overlap sum is also due one clock after its result inputs. The aligned starts are due `ALIGN_DLY` cycles after the lane starts. The bench drives each stimulus on the falling edge and checks the registered outputs shortly after the next rising edge. That rising edge is the first at which the design can present the result. For the aligned starts, the bench keeps its own history of the observed lane starts and compares against the entry `ALIGN_DLY` cycles back. A reference segment position kept in the bench, which advances only on accepted samples, supplies the expected lane ownership and start cycle for each sample.

// File: rtl/seg_sched_pkg.sv
package seg_sched_pkg;

  // strobes handed from control to datapath for the current input cycle
  typedef struct packed {
    logic accept;    // an input sample is taken this cycle
    logic toLaneB;   // the current segment belongs to lane B
    logic segStart;  // this sample opens a segment
  } sched_strobe_t;

endpackage

// File: rtl/seg_sched_ctrl.sv
module seg_sched_ctrl
  import seg_sched_pkg::*;
#(
  parameter int SEG_LEN = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output sched_strobe_t strobe
);

  localparam int FRAME = 2 * SEG_LEN;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(SEG_LEN);

  // position inside one A+B segment pair; moves only on accepted samples
  logic [CNT_W-1:0] pairPos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pairPos <= '0;
    end else if (inValid) begin
      if (pairPos == LAST_POS) pairPos <= '0;
      else                     pairPos <= pairPos + 1'b1;
    end
  end

  always_comb begin
    strobe.accept   = inValid;
    strobe.toLaneB  = (pairPos >= HALF_POS);
    strobe.segStart = (pairPos == '0) || (pairPos == HALF_POS);
  end

endmodule

// File: rtl/seg_sched_dp.sv
module seg_sched_dp
  import seg_sched_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int RES_W     = 20,
  parameter int ALIGN_DLY = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  sched_strobe_t          strobe,
  input  logic [IN_W-1:0]        inData,
  output logic [1:0]             laneValid,
  output logic [1:0][IN_W-1:0]   laneData,
  output logic [1:0]             laneStart,
  output logic [1:0]             alignStart,
  input  logic                   resAValid,
  input  logic [RES_W-1:0]       resAData,
  input  logic                   resBValid,
  input  logic [RES_W-1:0]       resBData,
  output logic                   outValid,
  output logic [RES_W+1:0]       outData
);

  localparam int OUT_W = RES_W + 2;

  // lane registers: the owning lane takes the sample, the other takes zero
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic ownsSeg;
    assign ownsSeg = (g == 1) ? strobe.toLaneB : !strobe.toLaneB;

    always_ff @(posedge clk) begin
      if (rst) begin
        laneValid[g] <= 1'b0;
        laneData[g]  <= '0;
        laneStart[g] <= 1'b0;
      end else begin
        laneValid[g] <= strobe.accept;
        laneData[g]  <= (strobe.accept && ownsSeg) ? inData : '0;
        laneStart[g] <= strobe.accept && ownsSeg && strobe.segStart;
      end
    end
  end

  // alignment delay on the start pulses
  if (ALIGN_DLY == 0) begin : g_nodly
    assign alignStart = laneStart;
  end else begin : g_dly
    logic [1:0][ALIGN_DLY-1:0] dlyLine;
    for (genvar g = 0; g < 2; g++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) dlyLine[g] <= '0;
        else if (ALIGN_DLY == 1) dlyLine[g] <= laneStart[g];
        else dlyLine[g] <= {dlyLine[g][ALIGN_DLY-2:0], laneStart[g]};
      end
      assign alignStart[g] = dlyLine[g][ALIGN_DLY-1];
    end
  end

  // overlap-add of the two result streams
  logic signed [OUT_W-1:0] addA, addB;
  assign addA = resAValid ? OUT_W'(signed'(resAData)) : '0;
  assign addB = resBValid ? OUT_W'(signed'(resBData)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= resAValid | resBValid;
      outData  <= addA + addB;
    end
  end

endmodule

// File: rtl/seg_sched_top.sv
module seg_sched_top
  import seg_sched_pkg::*;
#(
  parameter int SEG_LEN   = 256,
  parameter int IN_W      = 12,
  parameter int RES_W     = 20,
  parameter int ALIGN_DLY = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             laneAValid,
  output logic [IN_W-1:0]  laneAData,
  output logic             laneAStart,
  output logic             laneBValid,
  output logic [IN_W-1:0]  laneBData,
  output logic             laneBStart,
  output logic             alignStartA,
  output logic             alignStartB,
  input  logic             resAValid,
  input  logic [RES_W-1:0] resAData,
  input  logic             resBValid,
  input  logic [RES_W-1:0] resBData,
  output logic             outValid,
  output logic [RES_W+1:0] outData
);

  sched_strobe_t           strobe;
  logic [1:0]              laneValid;
  logic [1:0][IN_W-1:0]    laneData;
  logic [1:0]              laneStart;
  logic [1:0]              alignStart;

  seg_sched_ctrl #(.SEG_LEN(SEG_LEN)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe)
  );

  seg_sched_dp #(.IN_W(IN_W), .RES_W(RES_W), .ALIGN_DLY(ALIGN_DLY)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .inData     (inData),
    .laneValid  (laneValid),
    .laneData   (laneData),
    .laneStart  (laneStart),
    .alignStart (alignStart),
    .resAValid  (resAValid),
    .resAData   (resAData),
    .resBValid  (resBValid),
    .resBData   (resBData),
    .outValid   (outValid),
    .outData    (outData)
  );

  assign laneAValid  = laneValid[0];
  assign laneAData   = laneData[0];
  assign laneAStart  = laneStart[0];
  assign laneBValid  = laneValid[1];
  assign laneBData   = laneData[1];
  assign laneBStart  = laneStart[1];
  assign alignStartA = alignStart[0];
  assign alignStartB = alignStart[1];

endmodule

// File: rtl/seg_sched_chk.sv
module seg_sched_chk #(
  parameter int IN_W  = 12,
  parameter int RES_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             laneAValid,
  input logic [IN_W-1:0]  laneAData,
  input logic             laneAStart,
  input logic             laneBValid,
  input logic [IN_W-1:0]  laneBData,
  input logic             laneBStart,
  input logic             resAValid,
  input logic             resBValid,
  input logic             outValid
);

  assert_one_start_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({laneAStart, laneBStart}));

  assert_start_has_data_R5: assert property (@(posedge clk) disable iff (rst)
    (laneAStart |-> laneAValid) and (laneBStart |-> laneBValid));

  assert_lanes_paired_R4: assert property (@(posedge clk) disable iff (rst)
    laneAValid == laneBValid);

  assert_zero_tail_R4: assert property (@(posedge clk) disable iff (rst)
    (laneAData != '0) |-> (laneBData == '0));

  assert_gap_no_lane_R6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!laneAValid && !laneBValid && !laneAStart && !laneBStart));

  assert_out_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (resAValid || resBValid) |=> outValid);

  assert_out_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!resAValid && !resBValid) |=> !outValid);

endmodule

bind seg_sched_top seg_sched_chk #(.IN_W(IN_W), .RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .laneAValid (laneAValid),
  .laneAData  (laneAData),
  .laneAStart (laneAStart),
  .laneBValid (laneBValid),
  .laneBData  (laneBData),
  .laneBStart (laneBStart),
  .resAValid  (resAValid),
  .resBValid  (resBValid),
  .outValid   (outValid)
);

// File: tb/seg_sched_top_tb_top.sv
module seg_sched_top_tb_top;

  localparam int SEG_LEN   = 256;
  localparam int IN_W      = 12;
  localparam int RES_W     = 20;
  localparam int OUT_W     = RES_W + 2;
  localparam int ALIGN_DLY = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [IN_W-1:0]  inData = '0;
  logic             laneAValid, laneAStart, laneBValid, laneBStart;
  logic [IN_W-1:0]  laneAData, laneBData;
  logic             alignStartA, alignStartB;
  logic             resAValid = 1'b0, resBValid = 1'b0;
  logic [RES_W-1:0] resAData = '0, resBData = '0;
  logic             outValid;
  logic [OUT_W-1:0] outData;

  int errors = 0;
  int checks = 0;
  logic [63:0] histA = '0, histB = '0;

  always #2 clk = ~clk;  // 250 MHz

  seg_sched_top #(.SEG_LEN(SEG_LEN), .IN_W(IN_W), .RES_W(RES_W), .ALIGN_DLY(ALIGN_DLY)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .laneAValid(laneAValid), .laneAData(laneAData), .laneAStart(laneAStart),
    .laneBValid(laneBValid), .laneBData(laneBData), .laneBStart(laneBStart),
    .alignStartA(alignStartA), .alignStartB(alignStartB),
    .resAValid(resAValid), .resAData(resAData),
    .resBValid(resBValid), .resBData(resBData),
    .outValid(outValid), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // adder vectors: {aV, aD, bV, bD, expV, expD}
  localparam int NV = 7;
  localparam int VW = 1 + RES_W + 1 + RES_W + 1 + OUT_W;
  localparam logic [NV-1:0][VW-1:0] VEC = '{
    {1'b1, 20'sd1000,     1'b1, -20'sd250,    1'b1, 22'sd750},
    {1'b1, 20'sh7FFFF,    1'b1, 20'sh7FFFF,   1'b1, 22'sd1048574},
    {1'b1, 20'sh80000,    1'b1, 20'sh80000,   1'b1, -22'sd1048576},
    {1'b1, -20'sd7,       1'b0, 20'sd999,     1'b1, -22'sd7},
    {1'b0, 20'sd555,      1'b1, 20'sd12345,   1'b1, 22'sd12345},
    {1'b0, 20'sd77,       1'b0, 20'sd88,      1'b0, 22'sd0},
    {1'b1, 20'sh7FFFF,    1'b1, 20'sh80000,   1'b1, -22'sd1}
  };

  // one streaming cycle with the bench's own segment position model
  int mPos = 0;
  task automatic stream_step(input bit v, input logic [IN_W-1:0] d);
    bit onB, first;
    @(negedge clk);
    inValid = v; inData = d;
    onB = (mPos / SEG_LEN) % 2 == 1;
    first = (mPos % SEG_LEN) == 0;
    @(posedge clk); #1;
    if (v) begin
      chk(laneAValid && laneBValid, "R4 both lanes valid", {laneAValid, laneBValid}, 3);
      chk(laneAData == (onB ? '0 : d), onB ? "R4 lane A zero tail" : "R3 lane A data",
          laneAData, onB ? 0 : d);
      chk(laneBData == (onB ? d : '0), onB ? "R3 lane B data" : "R4 lane B zero tail",
          laneBData, onB ? d : 0);
      chk(laneAStart == (first && !onB), "R5 lane A start", laneAStart, first && !onB);
      chk(laneBStart == (first && onB),  "R5 lane B start", laneBStart, first && onB);
      mPos = (mPos + 1) % (2 * SEG_LEN);
    end else begin
      chk(!laneAValid && !laneBValid && !laneAStart && !laneBStart
          && laneAData == '0 && laneBData == '0, "R6 gap idle",
          {laneAValid, laneBValid, laneAStart, laneBStart}, 0);
    end
    chk(alignStartA == histA[ALIGN_DLY-1], "R9 aligned start A", alignStartA, histA[ALIGN_DLY-1]);
    chk(alignStartB == histB[ALIGN_DLY-1], "R9 aligned start B", alignStartB, histB[ALIGN_DLY-1]);
    histA = {histA[62:0], laneAStart};
    histB = {histB[62:0], laneBStart};
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk({laneAValid, laneBValid, laneAStart, laneBStart, alignStartA, alignStartB, outValid} == '0
        && laneAData == '0 && laneBData == '0 && outData == '0, "R1 reset state",
        {laneAValid, laneBValid, laneAStart, laneBStart, outValid}, 0);
    rst = 1'b0;

    // R7 R8: overlap-add vector table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      {resAValid, resAData, resBValid, resBData} = v[VW-1:OUT_W+1];
      @(posedge clk); #1;
      chk(outValid == v[OUT_W], "R7 output valid", outValid, v[OUT_W]);
      if (v[OUT_W])
        chk(outData == v[OUT_W-1:0], "R8 overlap sum",
            $signed(outData), $signed(v[OUT_W-1:0]));
    end
    @(negedge clk);
    resAValid = 1'b0; resBValid = 1'b0;

    // R2: first accepted sample after reset goes to lane A with a start
    stream_step(1'b1, 12'hABC);
    chk(laneAStart && laneAData == 12'hABC, "R2 first sample lane A", laneAData, 12'hABC);

    // R3 R4 R5 R6 R9: long stream with gaps crossing several segments
    for (int k = 1; k < 1400; k++) begin
      bit v;
      v = (k % 7) != 3;
      stream_step(v, IN_W'((k * 37 + 5) & 12'hFFF));
    end
    for (int k = 0; k < ALIGN_DLY + 2; k++) stream_step(1'b0, 12'hFFF);

    // R1 R2: reset mid-stream returns to lane A
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!laneAValid && !laneBValid, "R1 reset mid-stream", {laneAValid, laneBValid}, 0);
    mPos = 0; histA = '0; histB = '0;
    stream_step(1'b1, 12'h5A5);
    chk(laneAStart && !laneBStart, "R2 restart on lane A", {laneAStart, laneBStart}, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule